// File: doc/BRIEF.md
# DMA Single-Transfer Bus Sequencer

This block carries out exactly one DMA transfer unit over a 16-bit internal bus that has two byte-lane enables. A one-clock start pulse captures a source address, a destination address, a unit-size bit and a wait-enable bit. The block then runs a read phase against the source, keeps the fetched datum in an internal 16-bit holding register, and runs a write phase against the destination. A 16-bit unit at an odd address cannot be moved in one bus cycle, so that side is split into two byte cycles. The source and the destination are split independently of each other.

Every bus cycle is held for one or two clocks, depending on the region its own address falls in. The fixed decode is: the register area below 0x0400, fast memory from 0x0400 to 0x7FFF, and waited memory from 0x8000 up. A wait-enable bit, latched at start, makes all memory slow. When the last write clock ends, the block gives a one-clock done pulse and presents the total number of bus clocks the unit used. It keeps that count until the next start it accepts.

Top module: `dma_unit_seq`

## Requirements
- R1: After reset, bus_req, bus_we, done and clk_count are all 0, and bus_be is 2'b00.
- R2: The first bus clock comes one clock after an accepted start. All read bus cycles come before all write bus cycles, and there is no idle clock between them. Within one bus cycle, bus_addr, bus_be and bus_we do not change. bus_we is 0 for reads and 1 for writes.
- R3: When unit16=0, each side uses exactly one byte cycle at its own address. Address bit 0 = 0 gives bus_be=2'b01, with the byte on bus_rdata[7:0]. Address bit 0 = 1 gives bus_be=2'b10, with the byte on bus_rdata[15:8]. The written byte is driven on both lanes of bus_wdata.
- R4: When unit16=1 and a side's address is even, that side uses one bus cycle at that address with bus_be=2'b11. The source word is written unchanged: the byte at the lower address is on bits [7:0].
- R5: When unit16=1 and a side's address is odd, that side uses two byte cycles. The first is at the address, with bus_be=2'b10, and carries the low byte. The second is at address+1, with bus_be=2'b01, and carries the high byte. Each side is split only when its own address is odd.
- R6: Each bus cycle lasts a number of clocks set by its own address. Addresses below 0x0400 take 2 clocks. Addresses 0x0400 to 0x7FFF take 1 clock. Addresses 0x8000 and up take 2 clocks. With wait_all=1 at start, every memory address takes 2 clocks.
- R7: At done, clk_count equals (read cycles × read length) + (write cycles × write length), which is the number of clocks bus_req was high. It holds that value until the next accepted start.
- R8: done is high for exactly one clock, one clock after the last write clock, and the block is idle on the next clock. A start pulse while a transfer is running, or during done, is ignored, and so is any change of the address, size or wait inputs in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a unit |
| src_addr | input | 16 | Source byte address |
| dst_addr | input | 16 | Destination byte address |
| unit16 | input | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| wait_all | input | 1 | 1 = insert the wait on all memory |
| bus_req | output | 1 | A bus cycle is in progress this clock |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_be | output | 2 | Byte-lane enables (bit 0 = low lane) |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled on the last clock of a read cycle |
| done | output | 1 | One-clock end-of-unit pulse |
| clk_count | output | 8 | Total bus clocks used by the last unit |

## Verification
A wrong step or tick register shows up on bus_addr, bus_be or bus_req in the same clock, because the cycle would come too early, at the wrong byte, or with the wrong length. The bench compares these outputs on every clock. A wrong capture into the holding register stays hidden during the read phase. It appears only in bus_wdata during the write phase, one to four clocks later. A miscounted total, or a latched input that changed during a transfer, shows at the done clock and in the idle clock after it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dma_region_decode.sv
module dma_region_decode #(
    parameter int ADDR_W    = 16,
    parameter int CYC_W     = 2,
    parameter int REG_LIMIT = 'h0400,
    parameter int WAIT_BASE = 'h8000,
    parameter int FAST_CYC  = 1,
    parameter int WAIT_CYC  = 2,
    parameter int REG_CYC   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wait_all,
    output logic [CYC_W-1:0]  cyc_len
);
    localparam logic [ADDR_W-1:0] REG_TOP  = ADDR_W'(REG_LIMIT);
    localparam logic [ADDR_W-1:0] SLOW_BOT = ADDR_W'(WAIT_BASE);

    always_comb begin
        if (addr < REG_TOP)
            cyc_len = CYC_W'(REG_CYC);
        else if (wait_all || addr >= SLOW_BOT)
            cyc_len = CYC_W'(WAIT_CYC);
        else
            cyc_len = CYC_W'(FAST_CYC);
    end
endmodule

// File: rtl/dma_lane_map.sv
module dma_lane_map #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    input  logic              unit16,
    input  logic [15:0]       hold,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [1:0]        cyc_be,
    output logic [15:0]       cyc_wdata,
    output logic              two_steps
);
    logic       word_acc;
    logic [7:0] byte_sel;

    always_comb begin
        two_steps = unit16 & base[0];
        word_acc  = unit16 & ~base[0];
        cyc_addr  = base + ADDR_W'(step);
        if (word_acc)
            cyc_be = 2'b11;
        else if (cyc_addr[0])
            cyc_be = 2'b10;
        else
            cyc_be = 2'b01;
        byte_sel  = step ? hold[15:8] : hold[7:0];
        cyc_wdata = word_acc ? hold : {byte_sel, byte_sel};
    end
endmodule

// File: rtl/dma_unit_seq.sv
module dma_unit_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int CYC_W     = 2,
    parameter int REG_LIMIT = 'h0400,
    parameter int WAIT_BASE = 'h8000,
    parameter int FAST_CYC  = 1,
    parameter int WAIT_CYC  = 2,
    parameter int REG_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              unit16,
    input  logic              wait_all,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_be,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    output logic              done,
    output logic [CNT_W-1:0]  clk_count
);
    localparam int MAX_CYC = (REG_CYC > WAIT_CYC) ?
                             ((REG_CYC > FAST_CYC) ? REG_CYC : FAST_CYC) :
                             ((WAIT_CYC > FAST_CYC) ? WAIT_CYC : FAST_CYC);
    localparam int MAX_TOTAL = 4 * MAX_CYC;

    typedef struct packed {
        seq_state_t        st;
        logic              step;
        logic [CYC_W-1:0]  tick;
        logic [15:0]       hold;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              u16;
        logic              wt;
    } seq_t;

    seq_t q, d;

    logic [ADDR_W-1:0] side_base;
    logic [ADDR_W-1:0] cyc_addr;
    logic [1:0]        cyc_be;
    logic [15:0]       cyc_wdata;
    logic              two_steps;
    logic [CYC_W-1:0]  cyc_len;
    logic              active;
    logic              last_tick;
    logic [7:0]        rd_byte;

    assign side_base = (q.st == ST_WRITE) ? q.dst : q.src;

    dma_lane_map #(.ADDR_W(ADDR_W)) u_lane (
        .base      (side_base),
        .step      (q.step),
        .unit16    (q.u16),
        .hold      (q.hold),
        .cyc_addr  (cyc_addr),
        .cyc_be    (cyc_be),
        .cyc_wdata (cyc_wdata),
        .two_steps (two_steps)
    );

    dma_region_decode #(
        .ADDR_W(ADDR_W), .CYC_W(CYC_W), .REG_LIMIT(REG_LIMIT),
        .WAIT_BASE(WAIT_BASE), .FAST_CYC(FAST_CYC),
        .WAIT_CYC(WAIT_CYC), .REG_CYC(REG_CYC)
    ) u_region (
        .addr     (cyc_addr),
        .wait_all (q.wt),
        .cyc_len  (cyc_len)
    );

    assign active    = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign last_tick = (q.tick == (cyc_len - CYC_W'(1)));
    assign rd_byte   = (cyc_be == 2'b10) ? bus_rdata[15:8] : bus_rdata[7:0];

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_READ;
                    d.step = 1'b0;
                    d.tick = '0;
                    d.cnt  = '0;
                    d.src  = src_addr;
                    d.dst  = dst_addr;
                    d.u16  = unit16;
                    d.wt   = wait_all;
                end
            end
            ST_READ, ST_WRITE: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (last_tick) begin
                    d.tick = '0;
                    if (q.st == ST_READ) begin
                        if (cyc_be == 2'b11)
                            d.hold = bus_rdata;
                        else if (q.step)
                            d.hold[15:8] = rd_byte;
                        else
                            d.hold[7:0] = rd_byte;
                    end
                    if (two_steps && !q.step) begin
                        d.step = 1'b1;
                    end else begin
                        d.step = 1'b0;
                        d.st   = (q.st == ST_READ) ? ST_WRITE : ST_DONE;
                    end
                end else begin
                    d.tick = q.tick + CYC_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: ST_IDLE, default: '0};
        else
            q <= d;
    end

    assign bus_req   = active;
    assign bus_we    = (q.st == ST_WRITE);
    assign bus_addr  = active ? cyc_addr : '0;
    assign bus_be    = active ? cyc_be : 2'b00;
    assign bus_wdata = (q.st == ST_WRITE) ? cyc_wdata : 16'h0000;
    assign done      = (q.st == ST_DONE);
    assign clk_count = q.cnt;

    // R2: a bus cycle keeps its address, lanes and direction for its full length
    assert_cycle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && q.tick != '0) |-> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_we)));

    // R2: the write phase starts right after a read clock
    assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> ($past(bus_req) && !$past(bus_we)));

    // R3: byte units never use both lanes
    assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !q.u16) |-> ($countones(bus_be) == 1));

    // R7: the reported total lies in the possible range
    assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_count >= CNT_W'(2) && clk_count <= CNT_W'(MAX_TOTAL)));

    // R8: done lasts one clock and is followed by idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !bus_req));

    // R8: a start while busy leaves the latched request untouched
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start) |=> ($stable(q.src) && $stable(q.dst) && $stable(q.u16)));
endmodule

// File: tb/sim_dma_unit_seq.sv
module sim_dma_unit_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_addr = '0;
    logic [15:0] dst_addr = '0;
    logic        unit16 = 1'b0;
    logic        wait_all = 1'b0;
    logic        bus_req, bus_we, done;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_be;
    logic [7:0]  clk_count;

    int total_checks = 0;
    int bad_checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dma_unit_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .unit16(unit16), .wait_all(wait_all),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .clk_count(clk_count)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h3C;
    endfunction

    assign bus_rdata = {mem_byte({bus_addr[15:1], 1'b1}), mem_byte({bus_addr[15:1], 1'b0})};

    function automatic int ref_len(input logic [15:0] a, input logic w);
        if (a < 16'h0400) return 2;
        if (w || a >= 16'h8000) return 2;
        return 1;
    endfunction

    logic [15:0] e_addr[$], e_wd[$];
    logic [1:0]  e_be[$];
    logic        e_req[$], e_we[$], e_chk[$], e_done[$];
    int          e_cnt[$];
    string       e_tag[$];

    task automatic add(input logic rq, input logic we, input logic [15:0] a,
                       input logic [1:0] be, input logic [15:0] wd, input logic ck,
                       input logic dn, input int cn, input string tg);
        e_req.push_back(rq); e_we.push_back(we); e_addr.push_back(a);
        e_be.push_back(be); e_wd.push_back(wd); e_chk.push_back(ck);
        e_done.push_back(dn); e_cnt.push_back(cn); e_tag.push_back(tg);
    endtask

    task automatic side(input logic [15:0] base, input logic we, input logic u16,
                        input logic w, input logic [7:0] b0, input logic [7:0] b1,
                        inout int tot);
        string tg;
        if (u16 && !base[0]) begin
            tg = "R2_R4_R6";
            for (int i = 0; i < ref_len(base, w); i++)
                add(1, we, base, 2'b11, {b1, b0}, we, 0, 0, tg);
            tot += ref_len(base, w);
        end else if (u16) begin
            tg = "R2_R5_R6";
            for (int i = 0; i < ref_len(base, w); i++)
                add(1, we, base, 2'b10, {b0, b0}, we, 0, 0, tg);
            for (int i = 0; i < ref_len(base + 16'd1, w); i++)
                add(1, we, base + 16'd1, 2'b01, {b1, b1}, we, 0, 0, tg);
            tot += ref_len(base, w) + ref_len(base + 16'd1, w);
        end else begin
            tg = "R2_R3_R6";
            for (int i = 0; i < ref_len(base, w); i++)
                add(1, we, base, base[0] ? 2'b10 : 2'b01, {b0, b0}, we, 0, 0, tg);
            tot += ref_len(base, w);
        end
    endtask

    task automatic chk(input logic ok, input string tg, input string what,
                       input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] s, input logic [15:0] dd, input logic u16,
                       input logic w, input int poke);
        int tot = 0;
        e_req.delete(); e_we.delete(); e_addr.delete(); e_be.delete(); e_wd.delete();
        e_chk.delete(); e_done.delete(); e_cnt.delete(); e_tag.delete();
        side(s, 0, u16, w, mem_byte(s), mem_byte(s + 16'd1), tot);
        side(dd, 1, u16, w, mem_byte(s), mem_byte(s + 16'd1), tot);
        add(0, 0, 16'h0, 2'b00, 16'h0, 0, 1, tot, "R7_R8");
        add(0, 0, 16'h0, 2'b00, 16'h0, 0, 0, tot, "R7_R8");
        @(negedge clk);
        start = 1; src_addr = s; dst_addr = dd; unit16 = u16; wait_all = w;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < e_req.size(); i++) begin
            chk(bus_req == e_req[i], e_tag[i], "bus_req", bus_req, e_req[i]);
            chk(bus_we == e_we[i], e_tag[i], "bus_we", bus_we, e_we[i]);
            chk(done == e_done[i], e_tag[i], "done", done, e_done[i]);
            if (e_req[i]) begin
                chk(bus_addr == e_addr[i], e_tag[i], "bus_addr", bus_addr, e_addr[i]);
                chk(bus_be == e_be[i], e_tag[i], "bus_be", bus_be, e_be[i]);
            end
            if (e_chk[i])
                chk(bus_wdata == e_wd[i], e_tag[i], "bus_wdata", bus_wdata, e_wd[i]);
            if (!e_req[i])
                chk(int'(clk_count) == e_cnt[i], e_tag[i], "clk_count", clk_count, e_cnt[i]);
            if (i == poke) begin
                start = 1; src_addr = ~s; dst_addr = ~dd; unit16 = ~u16; wait_all = ~w;
            end else begin
                start = 0;
            end
            @(negedge clk);
        end
        start = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_req == 0, "R1", "bus_req", bus_req, 0);
        chk(bus_we == 0, "R1", "bus_we", bus_we, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(clk_count == 0, "R1", "clk_count", clk_count, 0);
        chk(bus_be == 0, "R1", "bus_be", bus_be, 0);
        rst_n = 1;
        @(negedge clk);
        chk(bus_req == 0, "R1", "bus_req idle", bus_req, 0);
        run(16'h0400, 16'h0500, 0, 0, -1);  // byte, even/even, fast
        run(16'h0011, 16'h0123, 0, 0, -1);  // byte, odd/odd, register area
        run(16'h9001, 16'h0402, 0, 0, -1);  // byte, odd/even, waited to fast
        run(16'h0600, 16'h0700, 1, 0, -1);  // word, even/even, fast
        run(16'h0601, 16'h9000, 1, 0, -1);  // word, odd src, even dst
        run(16'h8002, 16'h0401, 1, 0, -1);  // word, even src, odd dst
        run(16'h03FF, 16'h7FFF, 1, 0, -1);  // both split, crossing regions
        run(16'h0501, 16'h0701, 1, 1, -1);  // wait_all forces slow memory
        run(16'h0200, 16'h0A03, 1, 0, 1);   // R8: start while busy ignored
        run(16'h0C05, 16'h0D06, 0, 0, 2);   // R8: start during done ignored
        run(16'hFFFF, 16'h0800, 1, 0, -1);  // split wrapping to address 0
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            total_checks++;
            bad_checks++;
            $display("FAIL watchdog R8 act=%0d exp=%0d", cyc, 50000);
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end
endmodule